// File: doc/BRIEF.md
# Turn-Signal Lamp Sequencer

This block is a synchronous Moore machine that drives six tail lamps, three on each side of a vehicle, from three request lines: turn left, turn right and hazard. A single turn request lights its own side in a growing sweep of three steps, and then all lamps go dark for one clock. A hazard request, or both turn requests at once, lights all six lamps together for one clock, followed by one dark clock. The blinking rate is set by the clock the block is given. The flash divider, lamp drivers and input debouncing are outside this block.

By default the state register is the lamp vector itself, so each lamp has its own flip-flop. A parameter selects a compact three-bit state code instead, with the lamp pattern decoded from that code. In both variants the lamps depend only on registered state. A hazard request cuts short any turn sweep that is under way.

Top module: `turn_sequencer`

## Requirements
- R1: An active-high synchronous reset (`rst`) forces the dark state. On the clock edge that samples `rst` high, `lamps` becomes 6'b000000.
- R2: The lamp vector is {L3,L2,L1,R1,R2,R3} on bits [5:0]. The eight legal patterns are: dark 000000, left step one 001000, left step two 011000, left step three 111000, right step one 000100, right step two 000110, right step three 000111, and all-on 111111. No other pattern ever appears after reset.
- R3: In the dark state with no request active, the next pattern is dark.
- R4: In the dark state, `req_left` alone (`req_right` and `req_hazard` low) gives 001000 on the next edge.
- R5: In the dark state, `req_right` alone gives 000100 on the next edge.
- R6: In the dark state, `req_hazard` high, or `req_left` and `req_right` both high, gives 111111 on the next edge.
- R7: A left sweep advances 001000 → 011000 → 111000, one step per edge, while `req_hazard` is low. The values of `req_left` and `req_right` have no effect during the sweep.
- R8: A right sweep advances 000100 → 000110 → 000111, one step per edge, while `req_hazard` is low. The turn inputs have no effect during the sweep.
- R9: From left step one or two, or from right step one or two, `req_hazard` high gives 111111 on the next edge.
- R10: From 111000, 000111 or 111111, the next pattern is dark, whatever the inputs are.
- R11: With `COMPACT_CODE`=1 the state is held as three bits, coded dark 000, L1 001, L2 011, L3 010, R1 101, R2 111, R3 110, all-on 100. The lamp sequence is identical to the default variant for every state and input combination.
- R12: `lamps` changes only on a rising clock edge. A change on any request input between edges leaves `lamps` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock; one step per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_left | input | 1 | Left turn request |
| req_right | input | 1 | Right turn request |
| req_hazard | input | 1 | Hazard request |
| lamps | output | 6 | Lamp drives {L3,L2,L1,R1,R2,R3}, 1 = lit |

## Verification
Every lamp pattern is due exactly one rising edge after the requests that produce it are sampled. The bench drives the requests on the falling edge and reads `lamps` on the following falling edge, so each check sits one full register stage after its stimulus. To show that no input reaches `lamps` between edges, the bench changes the requests just after a falling edge and checks that `lamps` still holds the old pattern a quarter period later. It then checks the new pattern on the next falling edge. The exhaustive sweep resets the block, walks it to each of the eight states and applies each of the eight input combinations. Both variants are compared against the bench's own next-state model.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int SIDE_LAMPS = 3;
  localparam int LAMP_W     = 2 * SIDE_LAMPS;
  localparam int CODE_W     = 3;

  typedef logic [LAMP_W-1:0] lamp_t;
  typedef logic [CODE_W-1:0] code_t;

  // Lamp patterns, order {L3,L2,L1,R1,R2,R3}
  localparam lamp_t PAT_DARK = 6'b000_000;
  localparam lamp_t PAT_L1   = 6'b001_000;
  localparam lamp_t PAT_L2   = 6'b011_000;
  localparam lamp_t PAT_L3   = 6'b111_000;
  localparam lamp_t PAT_R1   = 6'b000_100;
  localparam lamp_t PAT_R2   = 6'b000_110;
  localparam lamp_t PAT_R3   = 6'b000_111;
  localparam lamp_t PAT_ALL  = 6'b111_111;

  // Compact codes
  localparam code_t CD_DARK = 3'b000;
  localparam code_t CD_L1   = 3'b001;
  localparam code_t CD_L2   = 3'b011;
  localparam code_t CD_L3   = 3'b010;
  localparam code_t CD_R1   = 3'b101;
  localparam code_t CD_R2   = 3'b111;
  localparam code_t CD_R3   = 3'b110;
  localparam code_t CD_ALL  = 3'b100;

  // Next lamp pattern from current pattern and decoded request events
  function automatic lamp_t lamp_next(lamp_t cur, logic go_left, logic go_right,
                                      logic go_flash, logic cut_sweep);
    lamp_t n;
    case (cur)
      PAT_DARK: begin
        if (go_flash)      n = PAT_ALL;
        else if (go_left)  n = PAT_L1;
        else if (go_right) n = PAT_R1;
        else               n = PAT_DARK;
      end
      PAT_L1:  n = cut_sweep ? PAT_ALL : PAT_L2;
      PAT_L2:  n = cut_sweep ? PAT_ALL : PAT_L3;
      PAT_R1:  n = cut_sweep ? PAT_ALL : PAT_R2;
      PAT_R2:  n = cut_sweep ? PAT_ALL : PAT_R3;
      default: n = PAT_DARK; // L3, R3, all-on, and any stray value
    endcase
    return n;
  endfunction

  function automatic code_t code_of(lamp_t p);
    code_t c;
    case (p)
      PAT_L1:  c = CD_L1;
      PAT_L2:  c = CD_L2;
      PAT_L3:  c = CD_L3;
      PAT_R1:  c = CD_R1;
      PAT_R2:  c = CD_R2;
      PAT_R3:  c = CD_R3;
      PAT_ALL: c = CD_ALL;
      default: c = CD_DARK;
    endcase
    return c;
  endfunction

  function automatic lamp_t lamps_of(code_t c);
    lamp_t p;
    case (c)
      CD_L1:   p = PAT_L1;
      CD_L2:   p = PAT_L2;
      CD_L3:   p = PAT_L3;
      CD_R1:   p = PAT_R1;
      CD_R2:   p = PAT_R2;
      CD_R3:   p = PAT_R3;
      CD_ALL:  p = PAT_ALL;
      default: p = PAT_DARK;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/tsq_request_decode.sv
module tsq_request_decode (
  input  logic req_left,
  input  logic req_right,
  input  logic req_hazard,
  output logic go_left,
  output logic go_right,
  output logic go_flash,
  output logic cut_sweep
);
  always_comb begin
    go_flash  = req_hazard | (req_left & req_right);
    go_left   = req_left  & ~req_right & ~req_hazard;
    go_right  = req_right & ~req_left  & ~req_hazard;
    cut_sweep = req_hazard;
  end
endmodule

// File: rtl/tsq_state_store.sv
module tsq_state_store #(
  parameter bit COMPACT_CODE = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [tsq_pkg::LAMP_W-1:0] nxt_lamps,
  output logic [tsq_pkg::LAMP_W-1:0] cur_lamps
);
  import tsq_pkg::*;

  generate
    if (COMPACT_CODE) begin : g_code
      code_t code_q;
      always_ff @(posedge clk) begin
        if (rst) code_q <= CD_DARK;
        else     code_q <= code_of(nxt_lamps);
      end
      assign cur_lamps = lamps_of(code_q);
    end else begin : g_lamp
      lamp_t lamp_q;
      always_ff @(posedge clk) begin
        if (rst) lamp_q <= PAT_DARK;
        else     lamp_q <= nxt_lamps;
      end
      assign cur_lamps = lamp_q;
    end
  endgenerate
endmodule

// File: rtl/turn_sequencer.sv
module turn_sequencer #(
  parameter bit COMPACT_CODE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_left,
  input  logic       req_right,
  input  logic       req_hazard,
  output logic [5:0] lamps
);
  import tsq_pkg::*;

  logic  go_left, go_right, go_flash, cut_sweep;
  lamp_t cur_lamps, nxt_lamps;

  tsq_request_decode u_dec (
    .req_left   (req_left),
    .req_right  (req_right),
    .req_hazard (req_hazard),
    .go_left    (go_left),
    .go_right   (go_right),
    .go_flash   (go_flash),
    .cut_sweep  (cut_sweep)
  );

  assign nxt_lamps = lamp_next(cur_lamps, go_left, go_right, go_flash, cut_sweep);

  tsq_state_store #(.COMPACT_CODE(COMPACT_CODE)) u_store (
    .clk       (clk),
    .rst       (rst),
    .nxt_lamps (nxt_lamps),
    .cur_lamps (cur_lamps)
  );

  assign lamps = cur_lamps;
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_left,
  input logic       req_right,
  input logic       req_hazard,
  input logic       go_flash,
  input logic       cut_sweep,
  input logic [5:0] lamps
);
  logic legal;
  assign legal = (lamps == 6'b000000) || (lamps == 6'b001000) || (lamps == 6'b011000) ||
                 (lamps == 6'b111000) || (lamps == 6'b000100) || (lamps == 6'b000110) ||
                 (lamps == 6'b000111) || (lamps == 6'b111111);

  p_reset_dark_r1: assert property (@(posedge clk) rst |=> lamps == 6'b000000);

  p_legal_pattern_r2: assert property (@(posedge clk) disable iff (rst) legal);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (lamps == 6'b000000 && !req_left && !req_right && !req_hazard) |=> lamps == 6'b000000);

  p_left_start_r4: assert property (@(posedge clk) disable iff (rst)
    (lamps == 6'b000000 && req_left && !req_right && !req_hazard) |=> lamps == 6'b001000);

  p_right_start_r5: assert property (@(posedge clk) disable iff (rst)
    (lamps == 6'b000000 && req_right && !req_left && !req_hazard) |=> lamps == 6'b000100);

  p_flash_start_r6: assert property (@(posedge clk) disable iff (rst)
    (lamps == 6'b000000 && go_flash) |=> lamps == 6'b111111);

  p_left_step_r7: assert property (@(posedge clk) disable iff (rst)
    (lamps == 6'b011000 && !req_hazard) |=> lamps == 6'b111000);

  p_right_step_r8: assert property (@(posedge clk) disable iff (rst)
    (lamps == 6'b000110 && !req_hazard) |=> lamps == 6'b000111);

  p_hazard_cut_r9: assert property (@(posedge clk) disable iff (rst)
    (cut_sweep && (lamps == 6'b001000 || lamps == 6'b011000 ||
                   lamps == 6'b000100 || lamps == 6'b000110)) |=> lamps == 6'b111111);

  p_return_dark_r10: assert property (@(posedge clk) disable iff (rst)
    (lamps == 6'b111000 || lamps == 6'b000111 || lamps == 6'b111111) |=> lamps == 6'b000000);
endmodule

bind turn_sequencer tsq_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_left   (req_left),
  .req_right  (req_right),
  .req_hazard (req_hazard),
  .go_flash   (go_flash),
  .cut_sweep  (cut_sweep),
  .lamps      (lamps)
);

// File: tb/turn_sequencer_test.sv
module turn_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rl = 1'b0, rr = 1'b0, rh = 1'b0;
  logic [5:0] lamps_w, lamps_c;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  turn_sequencer #(.COMPACT_CODE(1'b0)) uut (
    .clk(clk), .rst(rst), .req_left(rl), .req_right(rr), .req_hazard(rh), .lamps(lamps_w));

  turn_sequencer #(.COMPACT_CODE(1'b1)) uut_c (
    .clk(clk), .rst(rst), .req_left(rl), .req_right(rr), .req_hazard(rh), .lamps(lamps_c));

  // Stimulus table: {left,right,hazard, expected lamps after the edge}
  localparam bit [8:0] VEC [0:16] = '{
    {3'b000, 6'b000000}, // R3
    {3'b100, 6'b001000}, // R4
    {3'b010, 6'b011000}, // R7 right ignored mid sweep
    {3'b100, 6'b111000}, // R7
    {3'b100, 6'b000000}, // R10
    {3'b010, 6'b000100}, // R5
    {3'b000, 6'b000110}, // R8
    {3'b001, 6'b111111}, // R9
    {3'b111, 6'b000000}, // R10
    {3'b110, 6'b111111}, // R6 both turns
    {3'b000, 6'b000000}, // R10
    {3'b010, 6'b000100}, // R5
    {3'b001, 6'b111111}, // R9
    {3'b000, 6'b000000}, // R10
    {3'b100, 6'b001000}, // R4
    {3'b101, 6'b111111}, // R9
    {3'b000, 6'b000000}  // R10
  };

  // Bench model: states 0 dark,1 L1,2 L2,3 L3,4 R1,5 R2,6 R3,7 all-on
  function automatic int ref_next(int s, logic l, logic r, logic h);
    if (s == 0) begin
      if (h || (l && r)) return 7;
      if (l) return 1;
      if (r) return 4;
      return 0;
    end
    if (s == 1 || s == 2 || s == 4 || s == 5) return h ? 7 : s + 1;
    return 0;
  endfunction

  function automatic logic [5:0] ref_lamps(int s);
    int nl, nr;
    logic [2:0] lf, rt;
    nl = (s >= 1 && s <= 3) ? s : (s == 7 ? 3 : 0);
    nr = (s >= 4 && s <= 6) ? s - 3 : (s == 7 ? 3 : 0);
    lf = 3'b111 >> (3 - nl);
    rt = 3'b111 << (3 - nr);
    return {lf, rt};
  endfunction

  task automatic chk(string req, logic [5:0] exp);
    checks++;
    if (lamps_w !== exp) begin
      failures++;
      $display("FAIL %s per-lamp variant: lamps=%b expected=%b", req, lamps_w, exp);
    end
    checks++;
    if (lamps_c !== exp) begin
      failures++;
      $display("FAIL %s compact variant: lamps=%b expected=%b", req, lamps_c, exp);
    end
  endtask

  task automatic step(logic l, logic r, logic h);
    rl = l; rr = r; rh = h;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic walk_to(int s);
    do_reset();
    case (s)
      1: step(1, 0, 0);
      2: begin step(1, 0, 0); step(0, 0, 0); end
      3: begin step(1, 0, 0); step(0, 0, 0); step(0, 0, 0); end
      4: step(0, 1, 0);
      5: begin step(0, 1, 0); step(0, 0, 0); end
      6: begin step(0, 1, 0); step(0, 0, 0); step(0, 0, 0); end
      7: step(0, 0, 1);
      default: ;
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b0, 1'b0, 1'b0);
    chk("R1 reset", 6'b000000);
    rst = 1'b0;

    for (int i = 0; i < 17; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6]);
      chk("R2 table", VEC[i][5:0]);
    end

    // R1: reset in the middle of a sweep
    step(1, 0, 0);
    step(0, 0, 0);
    chk("R7 pre-reset", 6'b011000);
    rst = 1'b1;
    step(1, 0, 0);
    chk("R1 mid-sweep reset", 6'b000000);
    rst = 1'b0;

    // R12: input change between edges does not reach lamps
    step(0, 0, 0);
    rl = 1'b1;
    #(CLK_PERIOD/4);
    chk("R12 no path before edge", 6'b000000);
    @(posedge clk);
    @(negedge clk);
    chk("R12 after edge", 6'b001000);
    rh = 1'b1;
    #(CLK_PERIOD/4);
    chk("R12 hazard before edge", 6'b001000);
    @(posedge clk);
    @(negedge clk);
    chk("R9 after edge", 6'b111111);

    // R11: exhaustive next-state sweep, both variants
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 8; v++) begin
        walk_to(s);
        chk("R11 reach state", ref_lamps(s));
        step(v[2], v[1], v[0]);
        chk("R11 transition", ref_lamps(ref_next(s, v[2], v[1], v[0])));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule